// File: doc/BRIEF.md
# Asynchronous Static RAM Cycle Sequencer

This block sits between a synchronous host and an external asynchronous static RAM. It has active-low chip select, output enable and write enable, and one shared data bus. The host raises a single-word read or write request for one clock. The sequencer latches the request and drives the RAM pins in a fixed order, holding each phase for a number of clock cycles. It then returns a one-clock acknowledge. A read acknowledge carries the captured word.

Each electrical window of the RAM is its own parameter, counted in clock cycles:

- address setup
- write pulse width
- data setup before the end of a write
- chip select before the end of a write
- data hold
- address hold
- read access
- output enable time
- output disable time

Where several windows cover the same phase, the phase lasts as long as the longest of them. The data bus is split into an output word, an output enable and an input word, so the bus can be resolved at the pad.

While a cycle is in progress, `busy` is high and further requests are not taken. A new request is accepted on the first idle clock after the hold phase of the previous cycle.

Top module: `sram_seq`

## Requirements
- R1: After reset, `ram_cs_n`, `ram_oe_n` and `ram_we_n` are 1, and `ram_dq_oe`, `busy` and `ack` are 0.
- R2: A write accepted on an edge presents its address and data with all three strobes high for `T_AS` cycles. Then `ram_cs_n` and `ram_we_n` go low together while `ram_oe_n` stays high.
- R3: During a write, `ram_cs_n` and `ram_we_n` stay low for max(`T_WP`, `T_DS`, `T_CSW`) cycles.
- R4: After a write's strobes return high, address and data stay driven and unchanged for max(`T_DH`, `T_AH`) cycles. Then `busy` falls.
- R5: A read presents its address with the strobes high for `T_AS` cycles. Then `ram_cs_n` and `ram_oe_n` stay low for max(`T_RD`, `T_OE`) cycles, while `ram_we_n` stays high and `ram_dq_oe` stays 0.
- R6: Read data is sampled from `ram_dq_in` on the edge that ends the read-access phase. It appears on `rdata` together with a one-cycle `ack` in the first cycle after the strobes rise.
- R7: After a read's strobes rise, the address is held and the bus is left undriven for max(`T_AH`, `T_OZ`) cycles before `busy` falls.
- R8: While `busy` is high, `req` is ignored: neither the RAM address nor the RAM contents change because of it.
- R9: A write is acknowledged with a one-cycle `ack` in the first cycle after its strobes rise.
- R10: `ram_dq_oe` is never high while `ram_oe_n` is low. It rises no sooner than `T_OZ` cycles after `ram_oe_n` last rose.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Request strobe, taken when not busy |
| req_we | input | 1 | 1 for write, 0 for read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write word |
| busy | output | 1 | A cycle is in progress |
| ack | output | 1 | One-cycle completion pulse |
| rdata | output | DATA_W | Word captured by the last read |
| ram_addr | output | ADDR_W | RAM address pins |
| ram_cs_n | output | 1 | RAM chip select, active low |
| ram_oe_n | output | 1 | RAM output enable, active low |
| ram_we_n | output | 1 | RAM write enable, active low |
| ram_dq_out | output | DATA_W | Word driven onto the data bus |
| ram_dq_oe | output | 1 | Data-bus driver enable |
| ram_dq_in | input | DATA_W | Word seen on the data bus |

## Verification
The bench builds the block with these values:

| Parameter | Value |
|---|---|
| `T_AS` | 2 |
| `T_WP` | 3 |
| `T_DS` | 4 |
| `T_CSW` | 2 |
| `T_DH` | 1 |
| `T_AH` | 2 |
| `T_RD` | 3 |
| `T_OE` | 2 |
| `T_OZ` | 3 |

With these values, a different window sets the length of each phase. Data setup sets the write pulse, address hold sets the write hold, read access sets the access phase, and output disable sets the read hold. A phase length taken from the wrong parameter therefore shows up as a wrong cycle count. The RAM model returns corrupted data until the access count is met, so a read captured one edge early is caught. Requests placed back to back and a request injected mid-cycle exercise turnaround and hold-off.

// File: rtl/sram_seq.sv
module sram_seq #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 8,
  parameter int T_AS   = 1,
  parameter int T_WP   = 2,
  parameter int T_DS   = 2,
  parameter int T_CSW  = 2,
  parameter int T_DH   = 1,
  parameter int T_AH   = 1,
  parameter int T_RD   = 2,
  parameter int T_OE   = 1,
  parameter int T_OZ   = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              busy,
  output logic              ack,
  output logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] ram_addr,
  output logic              ram_cs_n,
  output logic              ram_oe_n,
  output logic              ram_we_n,
  output logic [DATA_W-1:0] ram_dq_out,
  output logic              ram_dq_oe,
  input  logic [DATA_W-1:0] ram_dq_in
);

  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int AS_N  = mx(T_AS, 1);
  localparam int WP_N  = mx(mx(T_WP, T_DS), mx(T_CSW, 1));
  localparam int WH_N  = mx(mx(T_DH, T_AH), 1);
  localparam int RA_N  = mx(mx(T_RD, T_OE), 1);
  localparam int RH_N  = mx(mx(T_AH, T_OZ), 1);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  typedef enum logic [2:0] {
    S_IDLE, S_WSET, S_WPUL, S_WHLD, S_RSET, S_RACC, S_RHLD
  } st_t;

  st_t               st;
  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              last;

  assign last = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata   <= '0;
      ack     <= 1'b0;
    end else begin
      ack <= 1'b0;
      case (st)
        S_IDLE: if (req) begin
          addr_q  <= req_addr;
          wdata_q <= req_wdata;
          cnt     <= CNT_W'(AS_N - 1);
          st      <= req_we ? S_WSET : S_RSET;
        end
        S_WSET: if (last) begin
          cnt <= CNT_W'(WP_N - 1);
          st  <= S_WPUL;
        end else cnt <= cnt - 1'b1;
        S_WPUL: if (last) begin
          cnt <= CNT_W'(WH_N - 1);
          st  <= S_WHLD;
          ack <= 1'b1;
        end else cnt <= cnt - 1'b1;
        S_WHLD: if (last) st <= S_IDLE;
                else cnt <= cnt - 1'b1;
        S_RSET: if (last) begin
          cnt <= CNT_W'(RA_N - 1);
          st  <= S_RACC;
        end else cnt <= cnt - 1'b1;
        S_RACC: if (last) begin
          rdata <= ram_dq_in;
          cnt   <= CNT_W'(RH_N - 1);
          st    <= S_RHLD;
          ack   <= 1'b1;
        end else cnt <= cnt - 1'b1;
        S_RHLD: if (last) st <= S_IDLE;
                else cnt <= cnt - 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy       = (st != S_IDLE);
  assign ram_addr   = addr_q;
  assign ram_dq_out = wdata_q;
  assign ram_we_n   = (st != S_WPUL);
  assign ram_oe_n   = (st != S_RACC);
  assign ram_cs_n   = ram_we_n && ram_oe_n;
  assign ram_dq_oe  = (st == S_WSET) || (st == S_WPUL) || (st == S_WHLD);

  logic [ADDR_W-1:0] addr_prev;
  logic [CNT_W-1:0]  addr_age, we_run, oz_gap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_prev <= '0;
      addr_age  <= CNT_MAX;
      we_run    <= '0;
      oz_gap    <= CNT_MAX;
    end else begin
      addr_prev <= ram_addr;
      if (ram_addr != addr_prev) addr_age <= CNT_W'(1);
      else if (addr_age != CNT_MAX) addr_age <= addr_age + 1'b1;
      if (!ram_we_n) we_run <= (we_run == CNT_MAX) ? we_run : we_run + 1'b1;
      else we_run <= '0;
      if (!ram_oe_n) oz_gap <= '0;
      else if (oz_gap != CNT_MAX) oz_gap <= oz_gap + 1'b1;
    end
  end

  assert_addr_setup_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ram_we_n) |-> (addr_age >= CNT_W'(T_AS)) && ram_oe_n && !ram_cs_n);

  assert_pulse_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ram_we_n) |-> (we_run >= CNT_W'(T_WP)) && (we_run >= CNT_W'(T_DS))
                        && (we_run >= CNT_W'(T_CSW)));

  assert_data_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ram_we_n) |-> ram_dq_oe && $stable(ram_dq_out) && $stable(ram_addr));

  assert_no_write_in_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_oe_n |-> ram_we_n);

  assert_ack_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);

  assert_busy_holds_addr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(ram_addr));

  assert_no_contention_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_oe_n |-> !ram_dq_oe);

  assert_turnaround_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ram_dq_oe) |-> oz_gap >= CNT_W'(T_OZ));

endmodule

// File: tb/sim_sram_seq.sv
module sim_sram_seq;
  localparam int AW = 8, DW = 8;
  localparam int T_AS = 2, T_WP = 3, T_DS = 4, T_CSW = 2, T_DH = 1;
  localparam int T_AH = 2, T_RD = 3, T_OE = 2, T_OZ = 3;
  localparam int EXP_SET = 2, EXP_WLOW = 4, EXP_WHLD = 2, EXP_RLOW = 3, EXP_RHLD = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, req_we = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic busy, ack, cs_n, oe_n, we_n, dq_oe;
  logic [DW-1:0] rdata, dq_out, dq_in;
  logic [AW-1:0] ram_addr;

  always #4 clk = ~clk;

  sram_seq #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(8), .T_AS(T_AS), .T_WP(T_WP),
    .T_DS(T_DS), .T_CSW(T_CSW), .T_DH(T_DH), .T_AH(T_AH), .T_RD(T_RD),
    .T_OE(T_OE), .T_OZ(T_OZ)) u0 (
    .clk(clk), .rst_n(rst_n), .req(req), .req_we(req_we), .req_addr(req_addr),
    .req_wdata(req_wdata), .busy(busy), .ack(ack), .rdata(rdata),
    .ram_addr(ram_addr), .ram_cs_n(cs_n), .ram_oe_n(oe_n), .ram_we_n(we_n),
    .ram_dq_out(dq_out), .ram_dq_oe(dq_oe), .ram_dq_in(dq_in));

  logic [DW-1:0] mem [256];
  int acc_cnt = 0;
  logic ram_drv;
  assign ram_drv = !cs_n && !oe_n;
  assign dq_in = ram_drv ? ((acc_cnt >= T_RD - 1) ? mem[ram_addr] : ~mem[ram_addr])
                         : (dq_oe ? dq_out : '0);

  initial for (int i = 0; i < 256; i++) mem[i] = DW'(i) ^ 8'hA5;

  always @(posedge clk) begin
    if (ram_drv) acc_cnt <= acc_cnt + 1; else acc_cnt <= 0;
    if (!cs_n && !we_n) mem[ram_addr] <= dq_oe ? dq_out : 8'h5A;
  end

  int tests = 0, fails = 0, gap = 100;
  bit done = 1'b0, prev_oe = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (!oe_n && dq_oe) begin
      fails++;
      $display("FAIL R10 contention actual=1 expected=0");
    end
    if (dq_oe && !prev_oe && gap < T_OZ) begin
      fails++;
      $display("FAIL R10 turnaround actual=%0d expected>=%0d", gap, T_OZ);
    end
    prev_oe = dq_oe;
    gap = oe_n ? gap + 1 : 0;
  end

  task automatic op(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                    input bit inject);
    int setup = 0, low = 0, hold = 0, acks = 0, ack_pos = -1, bad = 0;
    logic [DW-1:0] got = '0;
    req = 1'b1; req_we = we; req_addr = a; req_wdata = d;
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      if (k == 0) req = 1'b0;
      if (inject && k == 2) begin
        req = 1'b1; req_we = 1'b1; req_addr = a + 1'b1; req_wdata = 8'h77;
      end
      if (inject && k == 3) req = 1'b0;
      if (!busy) break;
      if (cs_n) begin if (low == 0) setup++; else hold++; end
      else low++;
      if (ack) begin acks++; ack_pos = hold; got = rdata; end
      if (ram_addr != a) bad++;
      if (we && (!oe_n || !dq_oe || dq_out != d)) bad++;
      if (!we && (!we_n || dq_oe)) bad++;
    end
    chk(setup == EXP_SET, we ? "R2 write setup" : "R5 read setup", setup, EXP_SET);
    chk(low == (we ? EXP_WLOW : EXP_RLOW), we ? "R3 write low" : "R5 read low",
        low, we ? EXP_WLOW : EXP_RLOW);
    chk(hold == (we ? EXP_WHLD : EXP_RHLD), we ? "R4 write hold" : "R7 read hold",
        hold, we ? EXP_WHLD : EXP_RHLD);
    chk(bad == 0, we ? "R4 pins during write" : "R7 pins during read", bad, 0);
    chk(acks == 1 && ack_pos == 1, we ? "R9 write ack" : "R6 read ack", ack_pos, 1);
    chk(!ack, "R9 ack ended", ack, 0);
    if (!we) chk(got == d, "R6 read data", got, d);
  endtask

  localparam logic [16:0] VEC [10] = '{
    {1'b1, 8'h10, 8'h3C}, {1'b1, 8'h11, 8'hC3}, {1'b0, 8'h10, 8'h3C},
    {1'b0, 8'h11, 8'hC3}, {1'b1, 8'h10, 8'hFF}, {1'b0, 8'h10, 8'hFF},
    {1'b0, 8'h20, 8'h85}, {1'b1, 8'h00, 8'h00}, {1'b0, 8'h00, 8'h00},
    {1'b0, 8'hFF, 8'h5A}};

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cs_n && oe_n && we_n, "R1 strobes idle", {cs_n, oe_n, we_n}, 7);
    chk(!dq_oe && !busy && !ack, "R1 outputs idle", {dq_oe, busy, ack}, 0);
    foreach (VEC[i]) op(VEC[i][16], VEC[i][15:8], VEC[i][7:0], 1'b0);
    op(1'b1, 8'h30, 8'h12, 1'b1);
    op(1'b0, 8'h31, 8'h94, 1'b0);
    chk(mem[8'h31] == 8'h94, "R8 injected write ignored", mem[8'h31], 8'h94);
    op(1'b0, 8'h30, 8'h12, 1'b1);
    op(1'b0, 8'h31, 8'h94, 1'b0);
    repeat (4) @(negedge clk);
    chk(!busy && !ack, "R8 idle after injected request", busy, 0);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule